// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache

This block is a small direct-mapped data cache for one processor that shares an atomic bus with other masters. It keeps one word per line and gives each line only two states, Valid and Invalid. Reads that find a Valid line with a matching tag are answered locally. Reads that miss fetch the word over the bus and fill the line. Every write goes to the bus, so memory always holds the newest value. Writes never allocate a line.

Coherence works by watching the bus. Whenever another master completes a write to a word this cache holds, that line drops to Invalid, and the next local read misses and fetches the fresh value from memory. The controller never answers on the bus, because memory always does. A bus transaction runs three phases in a fixed order. First the controller requests the bus and waits for a grant. Next it drives a command and address for exactly one cycle. Last it waits for the data acknowledge.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, `bus_req` is 0, `bus_cmd` is idle (2'b00) and `cpu_resp_valid` is 0, so the first read of any address misses.
- R2: A read that misses issues one bus read (`bus_cmd` = 2'b01), fills the line with `bus_rdata` and returns that word on `cpu_rdata` with `cpu_resp_valid` in the cycle after the acknowledge.
- R3: A read of a Valid line with a matching tag issues no bus transaction and returns the cached word in the cycle after acceptance.
- R4: Every accepted write, hit or miss, issues exactly one bus write (`bus_cmd` = 2'b10) carrying the address and data, and responds in the cycle after the acknowledge.
- R5: A write miss does not allocate: a later read of that address misses and goes to the bus.
- R6: A write hit updates the cached word, so a later read of it hits with the new data and no bus traffic.
- R7: A snooped write from another master (`snp_valid` and `snp_we`) to a held address makes the line Invalid and starts no bus activity. The next local read misses and returns the new memory value.
- R8: A snooped read (`snp_valid` with `snp_we` low) leaves the line Valid.
- R9: A snooped write to the same index with a different tag leaves the held line Valid.
- R10: `bus_req` stays high from the request until the acknowledge. A command is driven for exactly one cycle and only while `bus_gnt` is high.
- R11: If another master's write to the same address completes while a read miss waits for grant, the miss returns the later value from memory.
- R12: If a snooped write invalidates the line while a local write to that address waits for grant, the line stays Invalid after the write completes, so the next read misses.
- R13: Two addresses with the same index and different tags displace each other: a read of one after filling the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with the pulse after a read |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write data during the command cycle |
| bus_ack | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Read data with the acknowledge |
| snp_valid | input | 1 | A transaction from another master has completed |
| snp_we | input | 1 | The snooped transaction was a write |
| snp_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
The bench targets races between snooping and an outstanding local request. In one case a write from another master lands while a local read miss is still waiting for grant; a design that read memory too early or kept a stale copy would return the old word. In the other case a snoop invalidates a line under a pending write hit; a design that decided hit-or-miss only at acceptance would turn the line Valid again and later serve a read with no bus access. The bench also uses snoops to the right index with the wrong tag, which a design comparing only the index would wrongly invalidate, and checks that write misses do not allocate, which a design that allocated would show as a silent hit.

// File: rtl/wtc_pkg.sv
// Shared encodings for the write-through snooping cache.
// Assumes a two-bit bus command field decoded by memory and arbiter.
package wtc_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'b00,
        BUS_READ  = 2'b01,
        BUS_WRITE = 2'b10
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARB,
        PH_CMD,
        PH_DATA
    } bus_phase_e;
endpackage

// File: rtl/wtc_line_store.sv
// Direct-mapped line storage: valid bit, tag and one data word per line.
// Provides one combinational lookup, one write port (fill or write-hit
// update, which also sets Valid) and a snoop invalidate port.
// Assumes a write and an invalidate to the same line in one cycle
// resolve in favour of the write.
module wtc_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              snp_en,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag,
    output logic              snp_hit
);
    logic [LINES-1:0]  vld_vec;
    logic [TAG_W-1:0]  tag_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    // Lookup ports read the per-line registers.
    assign lk_valid = vld_vec[lk_idx];
    assign lk_tag   = tag_arr[lk_idx];
    assign lk_data  = dat_arr[lk_idx];
    assign snp_hit  = snp_en && vld_vec[snp_idx] && (tag_arr[snp_idx] == snp_tag);

    for (genvar i = 0; i < LINES; i++) begin : gen_line
        logic              vld_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] dat_q;
        logic              set_l;
        logic              kill_l;

        assign set_l  = wr_en && (wr_idx == IDX_W'(i));
        assign kill_l = snp_hit && (snp_idx == IDX_W'(i));

        // Valid bit: reset clears, write sets, snoop hit clears.
        always_ff @(posedge clk) begin
            if (!rst_n)      vld_q <= 1'b0;
            else if (set_l)  vld_q <= 1'b1;
            else if (kill_l) vld_q <= 1'b0;
        end

        // Tag and data capture on every write to this line.
        always_ff @(posedge clk) begin
            if (set_l) begin
                tag_q <= wr_tag;
                dat_q <= wr_data;
            end
        end

        assign vld_vec[i] = vld_q;
        assign tag_arr[i] = tag_q;
        assign dat_arr[i] = dat_q;

        // R7: a snoop hit without a competing write leaves the line Invalid.
        a_r7_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_l && !set_l) |=> !vld_q);
    end
endmodule

// File: rtl/wtc_bus_port.sv
// Bus master sequencer for one atomic transaction at a time:
// request/grant, one command/address cycle, then wait for acknowledge.
// Assumes the arbiter holds grant until the request drops.
module wtc_bus_port
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              busy,
    output logic              cur_we,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack
);
    bus_phase_e        phase_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Phase sequencer through arbitration, command and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start)   phase_q <= PH_ARB;
                PH_ARB:  if (bus_gnt) phase_q <= PH_CMD;
                PH_CMD:               phase_q <= PH_DATA;
                PH_DATA: if (bus_ack) phase_q <= PH_IDLE;
                default:              phase_q <= PH_IDLE;
            endcase
        end
    end

    // Request capture when a transaction is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (phase_q == PH_IDLE && start) begin
            we_q    <= start_we;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
        end
    end

    logic cmd_cycle;
    assign cmd_cycle = (phase_q == PH_CMD);

    assign busy      = (phase_q != PH_IDLE);
    assign cur_we    = we_q;
    assign cur_addr  = addr_q;
    assign cur_wdata = wdata_q;
    assign done      = (phase_q == PH_DATA) && bus_ack;
    assign bus_req   = busy;
    assign bus_cmd   = cmd_cycle ? (we_q ? BUS_WRITE : BUS_READ) : BUS_IDLE;
    assign bus_addr  = cmd_cycle ? addr_q  : '0;
    assign bus_wdata = cmd_cycle ? wdata_q : '0;

    // R10: a command is only driven while granted.
    a_r10_cmd_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BUS_IDLE) |-> bus_gnt);
    // R10: the command/address phase lasts exactly one cycle.
    a_r10_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BUS_IDLE) |=> (bus_cmd == BUS_IDLE));
    // R10: the request is held until the acknowledge arrives.
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
endmodule

// File: rtl/wt_snoop_cache.sv
// Write-through, no-write-allocate, direct-mapped cache controller with
// snoop invalidation. Read hits answer locally; misses and all writes use
// the bus. Another master's write to a held word invalidates it.
// Assumes an atomic bus, a snoop port that reports only other masters'
// completed transactions, and memory that always answers reads.
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              busy, cur_we, done;
    logic [ADDR_W-1:0] cur_addr, lk_addr;
    logic [DATA_W-1:0] cur_wdata, lk_data;
    logic              lk_valid, lk_hit, snp_hit;
    logic [TAG_W-1:0]  lk_tag;
    logic              accept, read_hit, start, wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              resp_q;
    logic [DATA_W-1:0] rdata_q;

    // Lookup address: the new request while idle, the held one while busy.
    assign lk_addr  = busy ? cur_addr : cpu_addr;
    assign lk_hit   = lk_valid && (lk_tag == lk_addr[ADDR_W-1:IDX_W]);

    assign cpu_ready = !busy;
    assign accept    = cpu_valid && !busy;
    assign read_hit  = accept && !cpu_we && lk_hit;
    assign start     = accept && !read_hit;

    // Fill on read completion; update on write completion only if still held.
    assign wr_en   = done && (!cur_we || lk_hit);
    assign wr_data = cur_we ? cur_wdata : bus_rdata;

    wtc_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (lk_addr[IDX_W-1:0]),
        .lk_valid(lk_valid),
        .lk_tag  (lk_tag),
        .lk_data (lk_data),
        .wr_en   (wr_en),
        .wr_idx  (cur_addr[IDX_W-1:0]),
        .wr_tag  (cur_addr[ADDR_W-1:IDX_W]),
        .wr_data (wr_data),
        .snp_en  (snp_valid && snp_we),
        .snp_idx (snp_addr[IDX_W-1:0]),
        .snp_tag (snp_addr[ADDR_W-1:IDX_W]),
        .snp_hit (snp_hit)
    );

    wtc_bus_port #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_we   (cpu_we),
        .start_addr (cpu_addr),
        .start_wdata(cpu_wdata),
        .busy       (busy),
        .cur_we     (cur_we),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .done       (done),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack)
    );

    // Response pulse and read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            resp_q <= read_hit || done;
            if (read_hit)              rdata_q <= lk_data;
            else if (done && !cur_we)  rdata_q <= bus_rdata;
        end
    end

    assign cpu_resp_valid = resp_q;
    assign cpu_rdata      = rdata_q;

    // R3: a read hit answers next cycle and leaves the bus alone.
    a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        read_hit |=> (!bus_req && cpu_resp_valid));
    // R2: an accepted read miss requests the bus.
    a_r2_miss_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && !lk_hit) |=> bus_req);
    // R4: every accepted write requests the bus.
    a_r4_write_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we) |=> bus_req);
    // R2/R4: a completed data phase is answered on the next cycle.
    a_r2_done_resp: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cpu_resp_valid);
    // R7: without a processor request, snooping never starts bus activity.
    a_r7_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !accept) |=> !bus_req);
endmodule

// File: tb/tb_wt_snoop_cache.sv
// Directed bench: bus arbiter and memory model, processor and snoop tasks.
module tb_wt_snoop_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_resp_valid;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic snp_valid = 1'b0, snp_we = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    int checks = 0, fails = 0;
    int bus_count = 0, proto_viol = 0, gnt_delay = 0;
    logic [1:0] last_cmd = 2'b00;
    logic [DW-1:0] mem [64];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Arbiter and memory model, driven on the falling edge.
    initial begin
        logic pend = 0, pwr = 0, prev_req = 0, prev_ack = 0;
        logic [1:0] prev_cmd = 0;
        logic [AW-1:0] paddr = '0;
        logic [DW-1:0] pdata = '0;
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (bus_cmd != 2'b00 && !bus_gnt) proto_viol++;
            if (bus_cmd != 2'b00 && prev_cmd != 2'b00) proto_viol++;
            if (prev_req && !bus_req && !prev_ack) proto_viol++;
            prev_cmd = bus_cmd;
            prev_req = bus_req;
            bus_ack = 1'b0;
            if (pend) begin
                bus_ack = 1'b1;
                bus_rdata = mem[paddr[5:0]];
                if (pwr) mem[paddr[5:0]] = pdata;
                pend = 0;
            end else if (bus_gnt && bus_cmd != 2'b00) begin
                pend = 1; pwr = (bus_cmd == 2'b10);
                paddr = bus_addr; pdata = bus_wdata;
                last_cmd = bus_cmd; bus_count++;
            end
            prev_ack = bus_ack;
            if (!bus_req) begin
                bus_gnt = 1'b0; wait_cnt = 0;
            end else if (!bus_gnt) begin
                if (wait_cnt >= gnt_delay) bus_gnt = 1'b1;
                else wait_cnt++;
            end
        end
    end

    task automatic cpu_issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1", "ready before issue", DW'(cpu_ready), 1);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic cpu_wait(output logic [DW-1:0] r, output int lat);
        lat = 1;
        while (!cpu_resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        r = cpu_rdata;
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] r, output int lat);
        cpu_issue(we, a, d);
        cpu_wait(r, lat);
    endtask

    task automatic snoop(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_we = we; snp_addr = a;
        if (we) mem[a[5:0]] = d;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1", "ready", DW'(cpu_ready), 1);
        check(bus_req == 1'b0, "R1", "bus_req", DW'(bus_req), 0);
        check(bus_cmd == 2'b00, "R1", "bus_cmd", DW'(bus_cmd), 0);
        check(cpu_resp_valid == 1'b0, "R1", "resp", DW'(cpu_resp_valid), 0);
    endtask

    task automatic t_miss_then_hit();
        logic [DW-1:0] r; int lat; int b0;
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0 + 1, "R1", "first read misses", DW'(bus_count - b0), 1);
        check(last_cmd == 2'b01, "R2", "read command code", DW'(last_cmd), 1);
        check(r == mem[5], "R2", "miss data", r, mem[5]);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0, "R3", "hit bus count", DW'(bus_count - b0), 0);
        check(r == mem[5], "R3", "hit data", r, mem[5]);
        check(lat == 1, "R3", "hit latency", DW'(lat), 1);
    endtask

    task automatic t_write_hit();
        logic [DW-1:0] r; int lat; int b0;
        b0 = bus_count;
        cpu_op(1'b1, 16'h0005, 32'hAAAA_0005, r, lat);
        check(bus_count == b0 + 1, "R4", "write hit on bus", DW'(bus_count - b0), 1);
        check(last_cmd == 2'b10, "R4", "write command code", DW'(last_cmd), 2);
        check(mem[5] == 32'hAAAA_0005, "R4", "memory written", mem[5], 32'hAAAA_0005);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0, "R6", "read after write hit stays local", DW'(bus_count - b0), 0);
        check(r == 32'hAAAA_0005, "R6", "updated cached word", r, 32'hAAAA_0005);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] r; int lat; int b0;
        b0 = bus_count;
        cpu_op(1'b1, 16'h0009, 32'hBBBB_0009, r, lat);
        check(bus_count == b0 + 1, "R4", "write miss on bus", DW'(bus_count - b0), 1);
        check(mem[9] == 32'hBBBB_0009, "R4", "memory written", mem[9], 32'hBBBB_0009);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0009, '0, r, lat);
        check(bus_count == b0 + 1, "R5", "no allocate on write miss", DW'(bus_count - b0), 1);
        check(r == 32'hBBBB_0009, "R5", "read data", r, 32'hBBBB_0009);
    endtask

    task automatic t_snoop_write();
        logic [DW-1:0] r; int lat; int b0; int quiet;
        snoop(1'b1, 16'h0005, 32'hCCCC_0005);
        quiet = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bus_req) quiet = 0;
        end
        check(quiet == 1, "R7", "snoop starts no bus activity", DW'(quiet), 1);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0 + 1, "R7", "invalidated line misses", DW'(bus_count - b0), 1);
        check(r == 32'hCCCC_0005, "R7", "fresh value", r, 32'hCCCC_0005);
    endtask

    task automatic t_snoop_read_and_alias();
        logic [DW-1:0] r; int lat; int b0;
        snoop(1'b0, 16'h0005, '0);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0, "R8", "snooped read keeps line", DW'(bus_count - b0), 0);
        snoop(1'b1, 16'h0015, 32'hDDDD_0015);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0, "R9", "other tag keeps line", DW'(bus_count - b0), 0);
        check(r == 32'hCCCC_0005, "R9", "data kept", r, 32'hCCCC_0005);
    endtask

    task automatic t_conflict();
        logic [DW-1:0] r; int lat; int b0;
        b0 = bus_count;
        cpu_op(1'b0, 16'h0015, '0, r, lat);
        check(bus_count == b0 + 1, "R13", "conflicting tag misses", DW'(bus_count - b0), 1);
        check(r == 32'hDDDD_0015, "R13", "conflict data", r, 32'hDDDD_0015);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0005, '0, r, lat);
        check(bus_count == b0 + 1, "R13", "displaced line misses", DW'(bus_count - b0), 1);
    endtask

    task automatic t_snoop_during_miss();
        logic [DW-1:0] r; int lat;
        gnt_delay = 4;
        cpu_issue(1'b0, 16'h0007, '0);
        snoop(1'b1, 16'h0007, 32'hEEEE_0007);
        cpu_wait(r, lat);
        check(r == 32'hEEEE_0007, "R11", "pending miss gets later value", r, 32'hEEEE_0007);
        gnt_delay = 0;
    endtask

    task automatic t_snoop_during_write();
        logic [DW-1:0] r; int lat; int b0;
        gnt_delay = 4;
        cpu_issue(1'b1, 16'h0009, 32'h1234_0009);
        snoop(1'b1, 16'h0009, 32'h5678_0009);
        cpu_wait(r, lat);
        gnt_delay = 0;
        check(mem[9] == 32'h1234_0009, "R12", "local write lands last", mem[9], 32'h1234_0009);
        b0 = bus_count;
        cpu_op(1'b0, 16'h0009, '0, r, lat);
        check(bus_count == b0 + 1, "R12", "line stays invalid", DW'(bus_count - b0), 1);
        check(r == 32'h1234_0009, "R12", "read data", r, 32'h1234_0009);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i * 32'h111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_write_hit();
        t_write_miss();
        t_snoop_write();
        t_snoop_read_and_alias();
        t_conflict();
        t_snoop_during_miss();
        t_snoop_during_write();
        check(proto_viol == 0, "R10", "bus phase rule violations", DW'(proto_viol), 0);
        finished = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule